// File: doc/BRIEF.md
# Byte Shift, Rotate and Bit-Manipulation Unit

This block is the datapath for the byte-wide shift, rotate and single-bit operations of a small accumulator-style processor. A decoder outside the block presents an operand byte, the current flag byte, a two-bit operation class, a three-bit operation selector and a bit index. It then pulses `start` for one cycle. On the next clock edge the unit registers the new byte and the new flag byte, and it raises `valid` for that one cycle.

The shift and rotate group follows the usual accumulator flag model. The carry receives the bit that leaves the byte. Sign, zero and even parity are taken from the new byte. Half-carry and subtract are cleared. The group also includes the undocumented left shift that inserts a one at the low end. The bit group tests, clears or sets one bit chosen by the index. Register-file access, memory operand fetch and instruction decode are handled by the surrounding core.

Top module: `srb_unit`

## Requirements
- R1: While `rst_n` is low and after reset is released, `result`, `flags_out` and `valid` read zero until the first `start`.
- R2: With class 0 (shift/rotate), selector 0 rotates left circularly and selector 1 rotates right circularly. In both cases the bit leaving the byte enters the opposite end and also the carry.
- R3: Selector 2 rotates left through carry: the old carry enters bit 0 and the old bit 7 becomes the carry. Selector 3 rotates right through carry: the old carry enters bit 7 and the old bit 0 becomes the carry.
- R4: Selector 4 shifts left and fills bit 0 with zero. Selector 5 shifts right and keeps bit 7. Selector 7 shifts right and fills bit 7 with zero. Each of these sends the bit leaving the byte to carry.
- R5: Selector 6 shifts left, forces bit 0 to one, and sends the old bit 7 to carry.
- R6: After any class-0 operation the flag byte holds only the following: bit 7 equal to the result's bit 7, bit 6 set when the result is zero, bit 2 set when the result has an even number of ones, and bit 0 equal to the new carry. Every other bit, including half-carry (bit 4) and subtract (bit 1), is zero.
- R7: Class 1 (bit test) returns the operand unchanged. Flag bit 6 is set exactly when the indexed operand bit is 0, bit 4 is set, and bit 1 is cleared. All other flag bits, carry included, pass through from `flags_in`.
- R8: Class 2 returns the operand with the indexed bit cleared, and class 3 returns it with the indexed bit set. Both pass `flags_in` through unchanged.
- R9: `valid` is high for exactly the one cycle that follows a cycle with `start` high. `result` and `flags_out` keep their values in every cycle that follows a cycle without `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation strobe |
| op_class | input | 2 | 0 shift/rotate, 1 bit test, 2 bit clear, 3 bit set |
| op_sel | input | 3 | Shift/rotate selector for class 0 |
| bit_idx | input | 3 | Bit index for classes 1 to 3 |
| operand | input | 8 | Operand byte |
| flags_in | input | 8 | Incoming flag byte |
| result | output | 8 | Registered result byte |
| flags_out | output | 8 | Registered flag byte |
| valid | output | 1 | One-cycle completion pulse |

## Verification
The bound checker checks a set of properties on every cycle. It checks the valid pulse and the holding of the outputs. It checks that half-carry and subtract are cleared after shifts. It checks that carry is kept and half-carry is set after a bit test. It checks the flag pass-through for bit clear and set, and the wrap-around of the circular left rotate. The result bytes of the other selectors, the parity and zero flags, and the handling of every bit index are shown only by the bench scenarios. These scenarios compare the outputs against a behavioural model on every clock. They cover edge patterns such as 0x00, 0x80, 0x01 and 0xFF, both carry-in values, and back-to-back and spaced strobes.

// File: rtl/srb_pkg.sv
package srb_pkg;

   localparam int FLAG_W = 8;
   localparam int FL_SGN = 7;
   localparam int FL_ZRO = 6;
   localparam int FL_HLF = 4;
   localparam int FL_PAR = 2;
   localparam int FL_SUB = 1;
   localparam int FL_CRY = 0;

   typedef enum logic [1:0] {
      CLS_SHIFT = 2'd0,
      CLS_TEST  = 2'd1,
      CLS_CLR   = 2'd2,
      CLS_SET   = 2'd3
   } srb_class_e;

   typedef enum logic [2:0] {
      SH_ROLC = 3'd0,
      SH_RORC = 3'd1,
      SH_ROLT = 3'd2,
      SH_RORT = 3'd3,
      SH_SHLA = 3'd4,
      SH_SHRA = 3'd5,
      SH_SHL1 = 3'd6,
      SH_SHRL = 3'd7
   } srb_shift_e;

endpackage

// File: rtl/srb_shifter.sv
module srb_shifter
   import srb_pkg::*;
#(
   parameter int DW = 8
) (
   input  srb_shift_e      sel,
   input  logic [DW-1:0]   din,
   input  logic            cin,
   output logic [DW-1:0]   dout,
   output logic            cout
);
   localparam int MSB = DW - 1;

   always_comb begin
      dout = din;
      cout = 1'b0;
      unique case (sel)
         SH_ROLC: begin dout = {din[MSB-1:0], din[MSB]};  cout = din[MSB]; end
         SH_RORC: begin dout = {din[0], din[MSB:1]};      cout = din[0];   end
         SH_ROLT: begin dout = {din[MSB-1:0], cin};       cout = din[MSB]; end
         SH_RORT: begin dout = {cin, din[MSB:1]};         cout = din[0];   end
         SH_SHLA: begin dout = {din[MSB-1:0], 1'b0};      cout = din[MSB]; end
         SH_SHRA: begin dout = {din[MSB], din[MSB:1]};    cout = din[0];   end
         SH_SHL1: begin dout = {din[MSB-1:0], 1'b1};      cout = din[MSB]; end
         SH_SHRL: begin dout = {1'b0, din[MSB:1]};        cout = din[0];   end
         default: begin dout = din;                       cout = 1'b0;     end
      endcase
   end
endmodule

// File: rtl/srb_parity.sv
module srb_parity #(
   parameter int DW          = 8,
   parameter bit REDUCE_FORM = 1'b1
) (
   input  logic [DW-1:0] din,
   output logic          even
);
   generate
      if (REDUCE_FORM) begin : g_reduce
         assign even = ~(^din);
      end else begin : g_chain
         logic [DW:0] acc;
         assign acc[0] = 1'b0;
         for (genvar i = 0; i < DW; i++) begin : g_stage
            assign acc[i+1] = acc[i] ^ din[i];
         end
         assign even = ~acc[DW];
      end
   endgenerate
endmodule

// File: rtl/srb_bitop.sv
module srb_bitop
   import srb_pkg::*;
#(
   parameter int DW = 8,
   localparam int IW = $clog2(DW)
) (
   input  srb_class_e    cls,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          sel_zero
);
   logic [DW-1:0] mask;

   generate
      for (genvar g = 0; g < DW; g++) begin : g_dec
         assign mask[g] = (idx == IW'(g));
      end
   endgenerate

   assign sel_zero = ~|(din & mask);

   always_comb begin
      unique case (cls)
         CLS_CLR: dout = din & ~mask;
         CLS_SET: dout = din | mask;
         default: dout = din;
      endcase
   end
endmodule

// File: rtl/srb_unit.sv
module srb_unit
   import srb_pkg::*;
#(
   parameter int DW          = 8,
   parameter bit REDUCE_PAR  = 1'b1,
   localparam int IW         = $clog2(DW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_class,
   input  logic [2:0]        op_sel,
   input  logic [IW-1:0]     bit_idx,
   input  logic [DW-1:0]     operand,
   input  logic [FLAG_W-1:0] flags_in,
   output logic [DW-1:0]     result,
   output logic [FLAG_W-1:0] flags_out,
   output logic              valid
);
   generate
      if (DW < 2 || (DW & (DW - 1)) != 0) begin : g_bad_width
         $error("srb_unit: DW must be a power of two of at least 2");
      end
   endgenerate

   srb_class_e          cls;
   srb_shift_e          sel;
   logic [DW-1:0]       sh_out, bit_out;
   logic                sh_cout, bit_zero, par_even;
   logic [DW-1:0]       nxt_res;
   logic [FLAG_W-1:0]   nxt_flg;

   assign cls = srb_class_e'(op_class);
   assign sel = srb_shift_e'(op_sel);

   srb_shifter #(.DW(DW)) u_shift (
      .sel  (sel),
      .din  (operand),
      .cin  (flags_in[FL_CRY]),
      .dout (sh_out),
      .cout (sh_cout)
   );

   srb_bitop #(.DW(DW)) u_bit (
      .cls      (cls),
      .idx      (bit_idx),
      .din      (operand),
      .dout     (bit_out),
      .sel_zero (bit_zero)
   );

   srb_parity #(.DW(DW), .REDUCE_FORM(REDUCE_PAR)) u_par (
      .din  (sh_out),
      .even (par_even)
   );

   always_comb begin
      nxt_flg = flags_in;
      nxt_res = bit_out;
      unique case (cls)
         CLS_SHIFT: begin
            nxt_res         = sh_out;
            nxt_flg         = '0;
            nxt_flg[FL_SGN] = sh_out[DW-1];
            nxt_flg[FL_ZRO] = ~|sh_out;
            nxt_flg[FL_PAR] = par_even;
            nxt_flg[FL_CRY] = sh_cout;
         end
         CLS_TEST: begin
            nxt_flg[FL_SUB] = 1'b0;
            nxt_flg[FL_HLF] = 1'b1;
            nxt_flg[FL_ZRO] = bit_zero;
         end
         default: nxt_flg = flags_in;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result    <= '0;
         flags_out <= '0;
         valid     <= 1'b0;
      end else begin
         valid <= start;
         if (start) begin
            result    <= nxt_res;
            flags_out <= nxt_flg;
         end
      end
   end
endmodule

// File: rtl/srb_unit_chk.sv
module srb_unit_chk
   import srb_pkg::*;
#(
   parameter int DW = 8,
   localparam int IW = $clog2(DW)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [1:0]        op_class,
   input logic [2:0]        op_sel,
   input logic [IW-1:0]     bit_idx,
   input logic [DW-1:0]     operand,
   input logic [FLAG_W-1:0] flags_in,
   input logic [DW-1:0]     result,
   input logic [FLAG_W-1:0] flags_out,
   input logic              valid
);
   a_r9_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> valid);

   a_r9_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !valid);

   a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(result) && $stable(flags_out)));

   a_r6_shift_clears_hn: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_class == 2'd0) |=> (!flags_out[FL_HLF] && !flags_out[FL_SUB]));

   a_r7_test_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_class == 2'd1) |=>
         (flags_out[FL_CRY] == $past(flags_in[FL_CRY]) && flags_out[FL_HLF]
          && !flags_out[FL_SUB] && result == $past(operand)));

   a_r8_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_class[1]) |=> (flags_out == $past(flags_in)));

   a_r2_rolc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_class == 2'd0 && op_sel == 3'd0) |=>
         (result[0] == $past(operand[DW-1]) && flags_out[FL_CRY] == $past(operand[DW-1])));
endmodule

bind srb_unit srb_unit_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .op_class  (op_class),
   .op_sel    (op_sel),
   .bit_idx   (bit_idx),
   .operand   (operand),
   .flags_in  (flags_in),
   .result    (result),
   .flags_out (flags_out),
   .valid     (valid)
);

// File: tb/srb_unit_test.sv
module srb_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] op_class = '0;
   logic [2:0] op_sel = '0;
   logic [2:0] bit_idx = '0;
   logic [7:0] operand = '0;
   logic [7:0] flags_in = '0;
   logic [7:0] result, flags_out;
   logic       valid;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [7:0] exp_res = '0, exp_flg = '0;
   logic       exp_val = 1'b0;
   string      exp_tag = "R1";
   string      flg_tag = "R1";

   always #4 clk = ~clk;

   srb_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
      .op_sel(op_sel), .bit_idx(bit_idx), .operand(operand),
      .flags_in(flags_in), .result(result), .flags_out(flags_out),
      .valid(valid)
   );

   task automatic model(input int cls, input int sel, input int idx,
                        input int a, input int fin,
                        output int r, output int f,
                        output string rtag, output string ftag);
      int c, ones;
      if (cls == 0) begin
         int cin = fin & 1;
         case (sel)
            0: begin c = (a >> 7) & 1; r = ((a << 1) | c) & 255; rtag = "R2"; end
            1: begin c = a & 1; r = (a >> 1) | (c << 7);         rtag = "R2"; end
            2: begin c = (a >> 7) & 1; r = ((a << 1) | cin) & 255; rtag = "R3"; end
            3: begin c = a & 1; r = (a >> 1) | (cin << 7);       rtag = "R3"; end
            4: begin c = (a >> 7) & 1; r = (a << 1) & 255;       rtag = "R4"; end
            5: begin c = a & 1; r = (a >> 1) | (a & 128);        rtag = "R4"; end
            6: begin c = (a >> 7) & 1; r = ((a << 1) | 1) & 255; rtag = "R5"; end
            default: begin c = a & 1; r = a >> 1;                rtag = "R4"; end
         endcase
         ones = 0;
         for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
         f = c;
         if (r >= 128) f += 128;
         if (r == 0) f += 64;
         if (ones % 2 == 0) f += 4;
         ftag = "R6";
      end else if (cls == 1) begin
         r = a;
         f = (fin & ~(64 | 2)) | 16 | ((((a >> idx) & 1) == 0) ? 64 : 0);
         rtag = "R7"; ftag = "R7";
      end else begin
         r = (cls == 2) ? (a & ~(1 << idx) & 255) : (a | (1 << idx));
         f = fin;
         rtag = "R8"; ftag = "R8";
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_res <= '0; exp_flg <= '0; exp_val <= 1'b0;
      end else begin
         exp_val <= start;
         if (start) begin
            int r, f; string rt, ft;
            model(op_class, op_sel, bit_idx, operand, flags_in, r, f, rt, ft);
            exp_res <= r[7:0]; exp_flg <= f[7:0];
            exp_tag <= rt; flg_tag <= ft;
         end
      end
   end

   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         n_cmp++;
         if (valid !== exp_val) begin
            n_bad++;
            $display("FAIL R9 valid: actual %b expected %b", valid, exp_val);
         end
         if (result !== exp_res) begin
            n_bad++;
            $display("FAIL %s result: actual %02h expected %02h", exp_tag, result, exp_res);
         end
         if (flags_out !== exp_flg) begin
            n_bad++;
            $display("FAIL %s flags: actual %02h expected %02h", flg_tag, flags_out, exp_flg);
         end
      end
   end

   task automatic issue(input int cls, input int sel, input int idx,
                        input int a, input int fin);
      @(negedge clk);
      start = 1'b1; op_class = cls[1:0]; op_sel = sel[2:0];
      bit_idx = idx[2:0]; operand = a[7:0]; flags_in = fin[7:0];
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         start = 1'b0;
         operand = $urandom; flags_in = $urandom;
         op_class = $urandom; op_sel = $urandom; bit_idx = $urandom;
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int pats[6] = '{8'h00, 8'h80, 8'h01, 8'hFF, 8'hA5, 8'h7E};
      repeat (3) @(negedge clk);
      // R1: reset state
      n_cmp++;
      if (result !== 8'h00 || flags_out !== 8'h00 || valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset: actual %02h/%02h/%b expected 00/00/0",
                  result, flags_out, valid);
      end
      rst_n = 1'b1;
      idle(2);
      // R2..R6: every selector, edge patterns, both carry-in values, back to back
      for (int s = 0; s < 8; s++)
         foreach (pats[p])
            for (int ci = 0; ci < 2; ci++)
               issue(0, s, 0, pats[p], ci ? 8'hFF : 8'h00);
      idle(3);
      // R7, R8: every bit index, spaced strobes to check holding (R9)
      for (int cls = 1; cls < 4; cls++)
         for (int i = 0; i < 8; i++) begin
            issue(cls, 0, i, 8'h5A, 8'hA9);
            idle(2);
            issue(cls, 0, i, 8'hFF, 8'h56);
            issue(cls, 0, i, 8'h00, 8'h01);
         end
      idle(2);
      // mixed random traffic
      for (int k = 0; k < 400; k++) begin
         if ($urandom_range(0, 3) == 0) idle(1);
         else issue($urandom_range(0, 3), $urandom_range(0, 7),
                    $urandom_range(0, 7), $urandom_range(0, 255),
                    $urandom_range(0, 255));
      end
      idle(4);
      finish_run();
   end
endmodule